// File: doc/BRIEF.md
# Flash Program/Erase Control Register

This block is the configuration and control register of a flash program/erase controller. Software writes it over a plain 32-bit register port: a one-cycle write strobe with write data, and a read port that shows the register state at all times. Four control bits choose and steer a high-voltage operation: erase select, program select, high-voltage enable and suspend request. Two status bits report on it: operation done and operation passed. The register only accepts writes that keep the controller in a legal state. When a single write asks to change more than one control bit, a fixed priority decides which one change is kept.

An internal sequencer stands in for the high-voltage operation, so that done and passed change over time as they would on silicon. It has six states. IDLE has no operation. RUN counts down the operation time. SUS_ENTER waits for the suspend to settle. SUSPENDED holds the operation paused. RESUME waits before the count restarts. FINISHED holds a completed operation until software drops the enable. Its transitions are as follows. IDLE goes to RUN on a legal enable set, which is the start. RUN goes to IDLE when the enable is cleared, which is the abort. RUN goes to SUS_ENTER on a suspend set. RUN goes to FINISHED when the count expires. SUS_ENTER goes to SUSPENDED when its delay expires. SUSPENDED goes to RESUME on a suspend clear, which is accepted only while the enable is 1. RESUME goes to RUN when its delay expires. FINISHED goes to IDLE when the enable is cleared, which is the normal end.

Top module: `fpe_ctrl_reg`

## Requirements
- R1: After reset the control bits read 0, done reads 1 and passed reads 0 (rd_data = 0x100).
- R2: rd_data bit 0 is erase select, bit 1 is program select, bit 2 is high-voltage enable, bit 3 is suspend request, bit 8 is done and bit 9 is passed. All other bits read 0. Write data bits 3:0 request new values for the four control bits.
- R3: The priority levels are erase select (bit 0) highest, then program select (bit 1), then enable (bit 2), then suspend (bit 3). Of the control bits a write asks to change, only the highest-priority one is considered. If its change is locked, the write has no effect. At most one control bit changes per cycle.
- R4: Writes to erase select and program select are ignored while the enable is 1 or an operation is in progress.
- R5: From IDLE, setting the enable is accepted only when suspend is 0, the inspect input is 0, and erase select or program select is 1. Otherwise the write is ignored. An accepted set clears done and passed on the same clock edge.
- R6: With no interruption, done rises and passed goes to 1 exactly OP_CYCLES clock edges after the edge that starts the operation.
- R7: Clearing the enable while done is 0 and suspend is 0 aborts the operation. On that edge done goes to 1 and passed goes to 0.
- R8: Clearing the enable after done has risen ends the operation normally, and passed keeps its value.
- R9: A suspend set is accepted only while the sequencer is in RUN, and it is ignored otherwise. Done rises SUSP_DLY edges later, and the remaining count is kept.
- R10: A suspend clear is accepted only in SUSPENDED with the enable at 1. Done falls RESUME_DLY edges later, and the count continues from where it paused.
- R11: From a suspend set until done rises, writes to the enable are ignored.
- R12: From a suspend clear until done falls, clearing the enable is ignored.
- R13: While suspended, the enable may be cleared and set again without aborting. Done stays 1 and passed is unchanged.
- R14: While inspect_en is 1, a write that sets the enable from IDLE is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Single-cycle write strobe |
| wr_data | input | 32 | Write data; bits 3:0 request control bit values |
| inspect_en | input | 1 | Inspection mode; blocks operation start when 1 |
| rd_data | output | 32 | Register contents and status |

## Verification
A write lands on the clock edge where wr_en is high. Its effect on the control bits, on a start and on an abort appears on rd_data just after that same edge. Done rises OP_CYCLES edges after a start edge, SUSP_DLY edges after a suspend edge, and falls RESUME_DLY edges after a resume edge; a paused count carries over unchanged. The bench drives each write for exactly one edge and samples rd_data at the next falling edge. It steps a reference model once per edge, so every expected value is tied to the edge count rather than to elapsed time.

// File: rtl/fpe_pkg.sv
package fpe_pkg;

    localparam int NCTRL  = 4;
    localparam int B_ERS  = 0;
    localparam int B_PGM  = 1;
    localparam int B_EHV  = 2;
    localparam int B_SUS  = 3;
    localparam int B_DONE = 8;
    localparam int B_PASS = 9;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RUN,
        ST_SUS_ENTER,
        ST_SUSPENDED,
        ST_RESUME,
        ST_FINISHED
    } seq_state_t;

    typedef struct packed {
        logic start;
        logic abort;
        logic finish;
        logic suspend;
        logic resume;
    } seq_evt_t;

endpackage

// File: rtl/fpe_wr_arb.sv
module fpe_wr_arb
    import fpe_pkg::*;
(
    input  logic             wr_en,
    input  logic [NCTRL-1:0] wr_bits,
    input  logic [NCTRL-1:0] cur,
    input  seq_state_t       st,
    input  logic             inspect_en,
    output logic [NCTRL-1:0] nxt,
    output seq_evt_t         evt
);

    logic [NCTRL-1:0] diff;
    logic [NCTRL-1:0] grant;
    logic [NCTRL:0]   seen;

    assign diff    = wr_en ? (wr_bits ^ cur) : '0;
    assign seen[0] = 1'b0;

    // keep only the lowest-indexed (highest priority) requested change
    for (genvar gi = 0; gi < NCTRL; gi++) begin : g_prio
        assign grant[gi]  = diff[gi] & ~seen[gi];
        assign seen[gi+1] = seen[gi] | diff[gi];
    end

    logic want_set;
    logic start_ok;
    logic sel_ok;
    logic accept;

    assign want_set = |(grant & wr_bits);
    assign start_ok = (st == ST_IDLE) && !cur[B_SUS] && !inspect_en &&
                      (cur[B_ERS] || cur[B_PGM]);

    always_comb begin
        evt    = '0;
        sel_ok = !cur[B_EHV] && (st == ST_IDLE);
        accept = 1'b0;
        if (grant[B_ERS] || grant[B_PGM]) begin
            accept = sel_ok;
        end else if (grant[B_EHV]) begin
            if (want_set) begin
                evt.start = start_ok;
                accept    = start_ok || (st == ST_SUSPENDED);
            end else begin
                evt.abort  = (st == ST_RUN);
                evt.finish = (st == ST_FINISHED);
                accept     = evt.abort || evt.finish || (st == ST_SUSPENDED);
            end
        end else if (grant[B_SUS]) begin
            if (want_set) begin
                evt.suspend = (st == ST_RUN);
            end else begin
                evt.resume = (st == ST_SUSPENDED) && cur[B_EHV];
            end
            accept = evt.suspend || evt.resume;
        end
        nxt = accept ? (cur ^ grant) : cur;
    end

endmodule

// File: rtl/fpe_hv_seq.sv
module fpe_hv_seq
    import fpe_pkg::*;
#(
    parameter int OP_CYCLES  = 12,
    parameter int SUSP_DLY   = 3,
    parameter int RESUME_DLY = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  seq_evt_t   evt,
    output seq_state_t st,
    output logic       done,
    output logic       pass
);

    localparam int MAX_DLY = (SUSP_DLY > RESUME_DLY) ? SUSP_DLY : RESUME_DLY;
    localparam int CNT_W   = $clog2(OP_CYCLES + 1);
    localparam int DLY_W   = $clog2(MAX_DLY + 1);

    seq_state_t       st_nxt;
    logic [CNT_W-1:0] op_cnt;
    logic [DLY_W-1:0] dly_cnt;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nxt;
    end

    // next state
    always_comb begin
        st_nxt = st;
        unique case (st)
            ST_IDLE:      if (evt.start) st_nxt = ST_RUN;
            ST_RUN: begin
                if (evt.abort)          st_nxt = ST_IDLE;
                else if (evt.suspend)   st_nxt = ST_SUS_ENTER;
                else if (op_cnt == CNT_W'(1)) st_nxt = ST_FINISHED;
            end
            ST_SUS_ENTER: if (dly_cnt == DLY_W'(1)) st_nxt = ST_SUSPENDED;
            ST_SUSPENDED: if (evt.resume) st_nxt = ST_RESUME;
            ST_RESUME:    if (dly_cnt == DLY_W'(1)) st_nxt = ST_RUN;
            ST_FINISHED:  if (evt.finish) st_nxt = ST_IDLE;
            default:      st_nxt = ST_IDLE;
        endcase
    end

    // outputs and counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done    <= 1'b1;
            pass    <= 1'b0;
            op_cnt  <= '0;
            dly_cnt <= '0;
        end else begin
            done <= (st_nxt != ST_RUN) && (st_nxt != ST_SUS_ENTER);
            if (evt.start || evt.abort)
                pass <= 1'b0;
            else if (st == ST_RUN && st_nxt == ST_FINISHED)
                pass <= 1'b1;

            if (evt.start)
                op_cnt <= CNT_W'(OP_CYCLES);
            else if (st == ST_RUN && st_nxt == ST_RUN)
                op_cnt <= op_cnt - CNT_W'(1);

            if (evt.suspend)
                dly_cnt <= DLY_W'(SUSP_DLY);
            else if (evt.resume)
                dly_cnt <= DLY_W'(RESUME_DLY);
            else if ((st == ST_SUS_ENTER || st == ST_RESUME) && dly_cnt != '0)
                dly_cnt <= dly_cnt - DLY_W'(1);
        end
    end

endmodule

// File: rtl/fpe_ctrl_reg.sv
module fpe_ctrl_reg
    import fpe_pkg::*;
#(
    parameter int OP_CYCLES  = 12,
    parameter int SUSP_DLY   = 3,
    parameter int RESUME_DLY = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [31:0] wr_data,
    input  logic        inspect_en,
    output logic [31:0] rd_data
);

    logic [NCTRL-1:0] ctrl_q;
    logic [NCTRL-1:0] ctrl_nxt;
    seq_evt_t         evt;
    seq_state_t       st;
    logic             done;
    logic             pass;
    logic             unused_hi;

    assign unused_hi = ^wr_data[31:NCTRL];

    fpe_wr_arb u_arb (
        .wr_en      (wr_en),
        .wr_bits    (wr_data[NCTRL-1:0]),
        .cur        (ctrl_q),
        .st         (st),
        .inspect_en (inspect_en),
        .nxt        (ctrl_nxt),
        .evt        (evt)
    );

    fpe_hv_seq #(
        .OP_CYCLES  (OP_CYCLES),
        .SUSP_DLY   (SUSP_DLY),
        .RESUME_DLY (RESUME_DLY)
    ) u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .evt   (evt),
        .st    (st),
        .done  (done),
        .pass  (pass)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctrl_q <= '0;
        else        ctrl_q <= ctrl_nxt;
    end

    always_comb begin
        rd_data                = '0;
        rd_data[NCTRL-1:0]     = ctrl_q;
        rd_data[B_DONE]        = done;
        rd_data[B_PASS]        = pass;
    end

endmodule

// File: rtl/fpe_ctrl_chk.sv
module fpe_ctrl_chk
    import fpe_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic [31:0] rd_data
);

    p_one_bit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(rd_data[NCTRL-1:0] ^ $past(rd_data[NCTRL-1:0])) <= 1);

    p_sel_lock_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rd_data[B_EHV]) |-> rd_data[B_PGM:B_ERS] == $past(rd_data[B_PGM:B_ERS]));

    p_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(rd_data[B_EHV]) && $past(rd_data[B_DONE]) && !$past(rd_data[B_SUS]))
        |-> (!rd_data[B_DONE] && !rd_data[B_PASS]));

    p_abort_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(rd_data[B_EHV]) && !$past(rd_data[B_DONE]) && !$past(rd_data[B_SUS]))
        |-> (rd_data[B_DONE] && !rd_data[B_PASS]));

    p_end_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(rd_data[B_EHV]) && $past(rd_data[B_DONE]) && !$past(rd_data[B_SUS]))
        |-> (rd_data[B_PASS] == $past(rd_data[B_PASS])));

    p_susp_enter_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_data[B_SUS]) |-> !rd_data[B_DONE]);

    p_resume_cond_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rd_data[B_SUS]) |-> (rd_data[B_EHV] && rd_data[B_DONE]));

    p_susp_lock_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[B_SUS] && !rd_data[B_DONE]) |=> $stable(rd_data[B_EHV]));

endmodule

bind fpe_ctrl_reg fpe_ctrl_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_data (rd_data)
);

// File: tb/tb_fpe_ctrl_reg.sv
`timescale 1ns/1ps
module tb_fpe_ctrl_reg;

    localparam int OPC = 12;
    localparam int SD  = 3;
    localparam int RD  = 2;
    localparam int PH_IDLE = 0, PH_RUN = 1, PH_SENTER = 2, PH_SUSP = 3, PH_RESUME = 4, PH_FIN = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        inspect_en = 1'b0;
    logic [31:0] rd_data;

    always #2 clk = ~clk;

    fpe_ctrl_reg #(.OP_CYCLES(OPC), .SUSP_DLY(SD), .RESUME_DLY(RD)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .inspect_en(inspect_en), .rd_data(rd_data)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit ended = 0;

    logic [3:0] m_ctrl = '0;
    logic       m_done = 1'b1;
    logic       m_pass = 1'b0;
    int         m_ph = PH_IDLE;
    int         m_cnt = 0;
    int         m_dly = 0;

    function automatic logic [31:0] m_rd(logic [3:0] c, logic d, logic p);
        return {22'b0, p, d, 4'b0, c};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // reference behaviour, one call per clock edge
    task automatic model_step(input logic we, input logic [31:0] d, input logic insp);
        logic [3:0] df;
        int  sel;
        bit  ev;
        ev  = 0;
        sel = -1;
        if (we) begin
            df = d[3:0] ^ m_ctrl;
            for (int i = 3; i >= 0; i--) if (df[i]) sel = i;
        end
        case (sel)
            0, 1: if (!m_ctrl[2] && m_ph == PH_IDLE) m_ctrl[sel] = d[sel];
            2: begin
                if (d[2]) begin
                    if (m_ph == PH_IDLE && !m_ctrl[3] && !insp && (m_ctrl[0] || m_ctrl[1])) begin
                        m_ctrl[2] = 1; m_ph = PH_RUN; m_cnt = OPC; m_done = 0; m_pass = 0; ev = 1;
                    end else if (m_ph == PH_SUSP) m_ctrl[2] = 1;
                end else begin
                    if (m_ph == PH_RUN) begin
                        m_ctrl[2] = 0; m_ph = PH_IDLE; m_done = 1; m_pass = 0; ev = 1;
                    end else if (m_ph == PH_FIN) begin
                        m_ctrl[2] = 0; m_ph = PH_IDLE;
                    end else if (m_ph == PH_SUSP) m_ctrl[2] = 0;
                end
            end
            3: begin
                if (d[3]) begin
                    if (m_ph == PH_RUN) begin m_ctrl[3] = 1; m_ph = PH_SENTER; m_dly = SD; ev = 1; end
                end else if (m_ph == PH_SUSP && m_ctrl[2]) begin
                    m_ctrl[3] = 0; m_ph = PH_RESUME; m_dly = RD; ev = 1;
                end
            end
            default: ;
        endcase
        if (!ev) begin
            case (m_ph)
                PH_RUN:    if (m_cnt == 1) begin m_ph = PH_FIN; m_done = 1; m_pass = 1; end else m_cnt--;
                PH_SENTER: if (m_dly == 1) begin m_ph = PH_SUSP; m_done = 1; end else m_dly--;
                PH_RESUME: if (m_dly == 1) begin m_ph = PH_RUN; m_done = 0; end else m_dly--;
                default: ;
            endcase
        end
    endtask

    task automatic step(input logic we, input logic [31:0] d, input logic insp);
        wr_en = we; wr_data = d; inspect_en = insp;
        @(posedge clk);
        model_step(we, d, insp);
        @(negedge clk);
        wr_en = 1'b0; inspect_en = 1'b0;
    endtask

    task automatic wr(input logic [31:0] d);
        step(1'b1, d, 1'b0);
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) step(1'b0, 32'h0, 1'b0);
    endtask

    task automatic expect_lit(input string tag, input logic [31:0] exp);
        check(tag, rd_data, exp);
        check({tag, " model"}, rd_data, m_rd(m_ctrl, m_done, m_pass));
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        expect_lit("R1 reset", 32'h100);

        // normal program
        wr(32'h2);  expect_lit("R2 program select", 32'h102);
        wr(32'h6);  expect_lit("R5 start program", 32'h006);
        idle(OPC-1); expect_lit("R6 still busy", 32'h006);
        idle(1);    expect_lit("R6 done and pass", 32'h306);
        wr(32'h7);  expect_lit("R4 erase select locked", 32'h306);
        wr(32'h2);  expect_lit("R8 normal end", 32'h302);

        // priority among simultaneous changes
        wr(32'h0);  expect_lit("R3 single change", 32'h300);
        wr(32'hF);  expect_lit("R3 all set keeps erase only", 32'h301);
        wr(32'hE);  expect_lit("R3 erase clear wins", 32'h300);
        wr(32'h6);  expect_lit("R3 program over enable", 32'h302);
        wr(32'h0);  expect_lit("R3 clear", 32'h300);

        // illegal enable sets
        wr(32'h4);  expect_lit("R5 no operation selected", 32'h300);
        wr(32'h8);  expect_lit("R9 suspend in idle", 32'h300);
        wr(32'h1);  expect_lit("R2 erase select", 32'h301);
        step(1'b1, 32'h5, 1'b1); expect_lit("R14 inspect blocks", 32'h301);

        // erase with abort
        wr(32'h5);  expect_lit("R5 start erase", 32'h005);
        idle(4);    expect_lit("R6 erase busy", 32'h005);
        wr(32'h1);  expect_lit("R7 abort", 32'h101);
        wr(32'h0);  expect_lit("R4 unlocked after abort", 32'h100);

        // suspend and resume
        wr(32'h2);  wr(32'h6); idle(3);
        wr(32'hE);  expect_lit("R9 suspend accepted", 32'h00E);
        wr(32'hA);  expect_lit("R11 enable write locked", 32'h00E);
        idle(SD-2); expect_lit("R9 suspend settling", 32'h00E);
        idle(1);    expect_lit("R9 suspended done", 32'h10E);
        wr(32'hA);  expect_lit("R13 enable cleared no abort", 32'h10A);
        wr(32'h2);  expect_lit("R10 resume needs enable", 32'h10A);
        wr(32'hE);  expect_lit("R13 enable set in suspend", 32'h10E);
        wr(32'h6);  expect_lit("R10 resume accepted", 32'h106);
        wr(32'h2);  expect_lit("R12 enable clear locked", 32'h106);
        idle(RD-1); expect_lit("R10 done falls", 32'h006);
        idle(OPC-4); expect_lit("R10 count resumed", 32'h006);
        idle(1);    expect_lit("R6 done after resume", 32'h306);
        wr(32'h2);  expect_lit("R8 end after resume", 32'h302);

        // constrained random against the reference
        for (int n = 0; n < 4000; n++) begin
            logic [31:0] d;
            logic        we;
            logic        ins;
            we  = ($urandom % 3) != 0;
            d   = (($urandom % 8) == 0) ? $urandom : ($urandom & 32'hF);
            ins = ($urandom % 16) == 0;
            step(we, d, ins);
            check("R3 R4 R5 R7 R9 R10 random", rd_data, m_rd(m_ctrl, m_done, m_pass));
        end
        finish_run();
    end

endmodule